// File: doc/BRIEF.md
# Inactivity-Timed Serial Core Clock Gate

This block decides whether the clock of a serial port core may run. It watches the four serial input lines (receive data, request-to-send, carrier detect, terminal ready) and a strobe that marks writes into the core's transmit buffer. Each watched source can be masked on its own. An inactivity counter, clocked by a free-running slow reference clock, is reloaded whenever an unmasked source shows activity. When it runs down to zero, the core clock enable is dropped. The enable comes back on the first unmasked activity that follows.

The four lines are asynchronous. Each passes through a synchronizer chain in the slow-clock domain. Activity on a line is any change of level, in either direction. The transmit-write strobe is already synchronous to the slow clock and counts as activity on the edge where it is sampled high. A global enable input overrides everything. With it low, the core clock is off. Setting it starts the clock with a full timeout. A timeout value of zero turns automatic stopping off.

The enable is a flop output that changes only on slow-clock edges, so it can drive a glitch-free clock gate cell directly. A status output reports whether the clock is running.

Top module: `idle_clock_gate`

## Requirements
- R1: After a synchronous reset, `core_clk_en` and `clk_running` are 0 and stay 0 until `gate_en` is set.
- R2: While `gate_en` is 0, `core_clk_en` is 0 from the edge after it was sampled low, and activity on any source has no effect. The counter is held at the timeout value.
- R3: A 0-to-1 change of `gate_en`, sampled on an edge, sets `core_clk_en` on that edge with the counter loaded to `timeout`. With no further activity, the enable then stays high for exactly `timeout` edges.
- R4: A level change in either direction on `rxd_in`, `rts_in`, `dcd_in` or `dtr_in` reloads the counter and sets `core_clk_en` on the third rising edge after the change. That is two synchronizer stages followed by the timer flop.
- R5: `txw_strobe` sampled high on an edge reloads the counter and sets `core_clk_en` on that same edge.
- R6: `src_mask` bit 0 masks receive data, bit 1 request-to-send, bit 2 carrier detect, bit 3 terminal ready and bit 4 the transmit-write strobe. A bit value of 1 masks that source. A masked source neither starts a stopped clock nor reloads the counter.
- R7: After the last reload, with no unmasked activity and a nonzero `timeout` T, `core_clk_en` stays high for T edges and falls on edge T.
- R8: Once stopped, `core_clk_en` stays 0 until unmasked activity or a new rise of `gate_en`.
- R9: With `timeout` equal to 0 and `gate_en` set, `core_clk_en` stays 1 whatever the activity.
- R10: `clk_running` always equals `core_clk_en`.
- R11: Activity while the clock runs reloads the counter in full, so the stop moves to T edges after the latest activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running slow reference clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Global permission for the core clock |
| src_mask | input | 5 | Per-source mask, 1 = ignore that source |
| timeout | input | CNT_W | Inactivity period in slow-clock cycles, 0 = never stop |
| rxd_in | input | 1 | Receive data line (asynchronous) |
| rts_in | input | 1 | Request-to-send line (asynchronous) |
| dcd_in | input | 1 | Carrier detect line (asynchronous) |
| dtr_in | input | 1 | Terminal ready line (asynchronous) |
| txw_strobe | input | 1 | One-cycle pulse per transmit buffer write, slow-clock domain |
| core_clk_en | output | 1 | Registered enable for the core clock gate |
| clk_running | output | 1 | Status: core clock currently enabled |

## Verification
The bench sweeps every mask value against every source and several small timeouts, including T = 1. It computes the exact edge on which the enable must rise and fall. A design with an off-by-one counter would stop one edge early or late. A design that skipped a synchronizer stage, or added one, would start on the wrong edge. A design that ignored falling edges would miss every second toggle. A mask decoded from the wrong bit would wake on a masked source. Directed cases cover a restart in the middle of a run, which a design that failed to reload would cut short. They also cover activity while the gate is disabled, a zero timeout that must never stop, and a re-enable that must start from a full count.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  localparam int NUM_LINES = 4;
  localparam int NUM_SRC   = NUM_LINES + 1;

  typedef enum int unsigned {
    SRC_RXD = 0,
    SRC_RTS = 1,
    SRC_DCD = 2,
    SRC_DTR = 3,
    SRC_TXW = 4
  } src_idx_e;

  typedef logic [NUM_SRC-1:0]   src_vec_t;
  typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/line_sync_edge.sv
module line_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic toggled
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q[0] <= din;
      prev_q     <= chain_q[LAST];
    end
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else     chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  assign toggled = chain_q[LAST] ^ prev_q;
endmodule

// File: rtl/activity_detect.sv
module activity_detect
  import clk_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  line_vec_t lines,
  input  logic      txw_strobe,
  input  src_vec_t  src_mask,
  output src_vec_t  src_hit,
  output logic      activity
);
  line_vec_t line_edge;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      line_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .din     (lines[g]),
        .toggled (line_edge[g])
      );
    end
  endgenerate

  assign src_hit  = {txw_strobe, line_edge} & ~src_mask;
  assign activity = |src_hit;
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_en,
  input  logic [CNT_W-1:0] timeout,
  input  logic             activity,
  output logic             run_en
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             gate_q;
  logic             run_q;
  logic             gate_rise;

  assign gate_rise = gate_en & ~gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      gate_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      gate_q <= gate_en;
      if (!gate_en) begin
        run_q <= 1'b0;
        cnt_q <= timeout;
      end else if (gate_rise || activity) begin
        run_q <= 1'b1;
        cnt_q <= timeout;
      end else if (timeout == '0) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q) begin
        if (cnt_q <= ONE) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign run_en = run_q;

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> !run_q); // R2
  AST_ACT_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (gate_en && activity) |=> (run_q && cnt_q == $past(timeout))); // R11
  AST_STAYS_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (gate_en && gate_q && !run_q && !activity && timeout != '0) |=> !run_q); // R8
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (gate_en && gate_q && run_q && !activity && timeout != '0 && cnt_q > ONE)
      |=> (run_q && cnt_q == $past(cnt_q) - ONE)); // R7
  AST_ZERO_NEVER_STOPS: assert property (@(posedge clk) disable iff (rst)
    (gate_en && timeout == '0) |=> run_q); // R9
endmodule

// File: rtl/idle_clock_gate.sv
module idle_clock_gate
  import clk_gate_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_en,
  input  logic [4:0]       src_mask,
  input  logic [CNT_W-1:0] timeout,
  input  logic             rxd_in,
  input  logic             rts_in,
  input  logic             dcd_in,
  input  logic             dtr_in,
  input  logic             txw_strobe,
  output logic             core_clk_en,
  output logic             clk_running
);
  line_vec_t lines;
  src_vec_t  src_hit;
  logic      activity;
  logic      run_en;

  always_comb begin
    lines          = '0;
    lines[SRC_RXD] = rxd_in;
    lines[SRC_RTS] = rts_in;
    lines[SRC_DCD] = dcd_in;
    lines[SRC_DTR] = dtr_in;
  end

  activity_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk        (clk),
    .rst        (rst),
    .lines      (lines),
    .txw_strobe (txw_strobe),
    .src_mask   (src_mask),
    .src_hit    (src_hit),
    .activity   (activity)
  );

  idle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .gate_en  (gate_en),
    .timeout  (timeout),
    .activity (activity),
    .run_en   (run_en)
  );

  assign core_clk_en = run_en;
  assign clk_running = run_en;

  AST_MASKED_TX_SILENT: assert property (@(posedge clk) disable iff (rst)
    (src_mask[SRC_TXW] && txw_strobe) |-> !src_hit[SRC_TXW]); // R6
  AST_RESET_OFF: assert property (@(posedge clk)
    $past(rst) |-> !core_clk_en); // R1
endmodule

// File: tb/idle_clock_gate_tb.sv
module idle_clock_gate_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             gate_en = 1'b0;
  logic [4:0]       src_mask = '0;
  logic [CNT_W-1:0] timeout = '0;
  logic [3:0]       lines = '0;
  logic             txw_strobe = 1'b0;
  logic             core_clk_en;
  logic             clk_running;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  idle_clock_gate #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .gate_en     (gate_en),
    .src_mask    (src_mask),
    .timeout     (timeout),
    .rxd_in      (lines[0]),
    .rts_in      (lines[1]),
    .dcd_in      (lines[2]),
    .dtr_in      (lines[3]),
    .txw_strobe  (txw_strobe),
    .core_clk_en (core_clk_en),
    .clk_running (clk_running)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string tag, input int info);
    checks++;
    if (core_clk_en !== exp) begin
      errors++;
      $display("FAIL %s: core_clk_en got %0b expected %0b (info %0d)", tag, core_clk_en, exp, info);
    end
    checks++;
    if (clk_running !== core_clk_en) begin
      errors++;
      $display("FAIL R10: clk_running got %0b expected %0b (info %0d)", clk_running, core_clk_en, info);
    end
  endtask

  // restart from a disabled state and let the clock run down
  task automatic rearm(input int t);
    timeout = CNT_W'(t);
    gate_en = 1'b0;
    tick();
    gate_en = 1'b1;
    repeat (t + 2) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tvals[4] = '{1, 2, 3, 5};
    // R1: reset state
    @(negedge clk);
    tick();
    chk(1'b0, "R1", 0);
    rst = 1'b0;
    repeat (3) tick();
    chk(1'b0, "R1", 1);

    // R3: rise of gate_en starts a full run of T edges
    timeout = CNT_W'(4);
    gate_en = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      tick();
      chk((i < 5) ? 1'b1 : 1'b0, "R3", i);
    end

    // R4 R5 R6 R7 R8: sweep timeouts, sources and every mask value
    foreach (tvals[k]) begin
      for (int src = 0; src < 5; src++) begin
        for (int m = 0; m < 32; m++) begin
          int t;
          int lat;
          logic hit;
          string tag;
          t = tvals[k];
          rearm(t);
          chk(1'b0, "R8", t);
          src_mask = 5'(m);
          hit = !src_mask[src];
          lat = (src < 4) ? 3 : 1;
          tag = !hit ? "R6" : (src < 4) ? "R4" : "R5";
          if (src < 4) lines[src] = ~lines[src];
          else txw_strobe = 1'b1;
          for (int i = 1; i <= lat + t + 1; i++) begin
            tick();
            txw_strobe = 1'b0;
            chk((hit && i >= lat && i < lat + t) ? 1'b1 : 1'b0,
                (i >= lat + t && hit) ? "R7" : tag, (src << 8) | m);
          end
        end
      end
    end
    src_mask = '0;

    // R11: retrigger during a run extends to T after the latest activity
    rearm(5);
    txw_strobe = 1'b1;
    tick();
    txw_strobe = 1'b0;
    chk(1'b1, "R11", 0);
    repeat (2) tick();
    txw_strobe = 1'b1;
    tick();
    txw_strobe = 1'b0;
    for (int i = 1; i <= 6; i++) begin
      chk((i <= 5) ? 1'b1 : 1'b0, "R11", i);
      tick();
    end

    // R2: clearing gate_en forces off, activity ignored while disabled
    txw_strobe = 1'b1;
    tick();
    txw_strobe = 1'b0;
    chk(1'b1, "R2", 0);
    gate_en = 1'b0;
    tick();
    chk(1'b0, "R2", 1);
    lines = ~lines;
    txw_strobe = 1'b1;
    for (int i = 2; i <= 7; i++) begin
      tick();
      txw_strobe = 1'b0;
      chk(1'b0, "R2", i);
    end

    // R9: zero timeout never stops
    timeout = '0;
    gate_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      chk(1'b1, "R9", i);
    end
    // R9 then leaving zero: a new activity gives a normal run of 2
    timeout = CNT_W'(2);
    txw_strobe = 1'b1;
    tick();
    txw_strobe = 1'b0;
    chk(1'b1, "R9", 100);
    tick();
    chk(1'b1, "R9", 101);
    tick();
    chk(1'b0, "R9", 102);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule